// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps the flags that firmware inspects after start-up to learn why the processor last came out of reset. Single-cycle strobes from the reset and power-management logic report each cause: power-on, brown-out, watchdog expiry while running, watchdog expiry while asleep, external reset while running, external reset while asleep, and entry into sleep. Each cause has its own update rule for each flag. A flag can be set, cleared, or left as it was.

Two flags follow those rules directly. One is a timeout flag and the other is a power-down flag, and software can read them but cannot write them. Two more flags sit in a power-control word: a power-on flag and a brown-out flag. Hardware only ever clears these two. Software sets them to 1, and when a later read finds one of them at 0, that shows the matching cause happened in between. A small address / write-enable port gives registered reads of both words and writes to the power-control word.

Top module: `rst_cause_reg`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, the flags hold their power-up values: timeout 1, power-down 1, power-on 0, brown-out equal to parameter `BOR_PON_VAL` (default 1). The flags word sits at address 0 with the timeout flag in bit 1 and the power-down flag in bit 0. The power-control word sits at address 1 with the power-on flag in bit 1 and the brown-out flag in bit 0.
- R2: A power-on strobe loads the same values as reset: power-on 0, brown-out `BOR_PON_VAL`, timeout 1, power-down 1.
- R3: When `bod_mode` is not 00, a brown-out strobe clears the brown-out flag and sets both the timeout and power-down flags. The power-on flag does not change.
- R4: When `bod_mode` is 00, a brown-out strobe changes no flag.
- R5: A watchdog strobe while running clears the timeout flag and changes no other flag.
- R6: A watchdog wake-up strobe from sleep clears both the timeout and power-down flags. The power-control flags do not change.
- R7: An external reset strobe while running changes no flag. An external reset strobe during sleep sets the timeout flag to 1 and clears the power-down flag.
- R8: A sleep-entry strobe sets the timeout flag to 1 and clears the power-down flag.
- R9: A write to address 1 loads `wdata` bit 1 into the power-on flag and `wdata` bit 0 into the brown-out flag. A write to address 0 changes nothing.
- R10: `rdata` is registered and shows the word addressed in the previous cycle. Bits above bit 1 read 0, and any address other than 0 or 1 reads 0.
- R11: A write in a cycle that also carries an effective event strobe is discarded. An effective strobe is any strobe except a brown-out strobe with `bod_mode` 00.
- R12: When several strobes coincide, only the highest-priority one takes effect. The order from highest to lowest is: power-on, brown-out (when enabled), watchdog in sleep, watchdog while running, external reset in sleep, external reset while running, sleep entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, loads power-up values |
| ev_pon | input | 1 | Power-on reset strobe |
| ev_brown | input | 1 | Brown-out reset strobe |
| ev_wdt_sleep | input | 1 | Watchdog wake-up from sleep strobe |
| ev_wdt_run | input | 1 | Watchdog reset while running strobe |
| ev_ext_sleep | input | 1 | External reset during sleep strobe |
| ev_ext_run | input | 1 | External reset while running strobe |
| ev_sleep | input | 1 | Sleep entry strobe |
| bod_mode | input | BOD_W | Brown-out detector mode, 00 means disabled |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write enable |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |

## Verification
The hardest case to reach is a collision: a write arriving in the same cycle as a strobe that changes nothing by itself, such as an external reset while running or a disabled brown-out. In that case only the fate of the write shows whether arbitration worked. The bench drives the write and the strobe on the same clock edge and then reads the power-control word back. It also pairs strobes so that a lower-priority rule would leave visibly different flags from the winning one. For example, a watchdog strobe while running paired with sleep entry would set the timeout flag if sleep entry won, but clears it when the watchdog wins.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  localparam int NUM_EV = 7;

  // Bit positions that firmware decodes
  localparam int TMO_BIT = 1;
  localparam int PDN_BIT = 0;
  localparam int PON_BIT = 1;
  localparam int BOR_BIT = 0;

  // Event codes; code value minus one equals strobe index (priority order)
  typedef enum logic [2:0] {
    EV_NONE      = 3'd0,
    EV_PON       = 3'd1,
    EV_BROWN     = 3'd2,
    EV_WDT_SLEEP = 3'd3,
    EV_WDT_RUN   = 3'd4,
    EV_EXT_SLEEP = 3'd5,
    EV_EXT_RUN   = 3'd6,
    EV_SLEEP     = 3'd7
  } rc_event_e;

  typedef struct packed {
    logic tmo;
    logic pdn;
    logic pon;
    logic bor;
  } rc_flags_t;

endpackage

// File: rtl/rst_cause_arb.sv
module rst_cause_arb
  import rst_cause_pkg::*;
(
  input  logic [NUM_EV-1:0] strobe,
  input  logic              bod_en,
  output rc_event_e         ev,
  output logic              ev_any
);

  logic [NUM_EV-1:0] eff;

  // Mask the brown-out strobe when the detector is disabled
  for (genvar g = 0; g < NUM_EV; g++) begin : g_mask
    if (g == int'(EV_BROWN) - 1) begin : g_brown
      assign eff[g] = strobe[g] & bod_en;
    end else begin : g_plain
      assign eff[g] = strobe[g];
    end
  end

  // Index 0 has highest priority; scan low priority first so high overrides
  always_comb begin
    ev = EV_NONE;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (eff[i]) ev = rc_event_e'(3'(i + 1));
    end
  end

  assign ev_any = (ev != EV_NONE);

endmodule

// File: rtl/rst_cause_next.sv
module rst_cause_next
  import rst_cause_pkg::*;
#(
  parameter logic BOR_PON_VAL = 1'b1
) (
  input  rc_flags_t  cur,
  input  rc_event_e  ev,
  input  logic       sw_wr,
  input  logic       sw_pon,
  input  logic       sw_bor,
  output rc_flags_t  nxt
);

  always_comb begin
    nxt = cur;
    unique case (ev)
      EV_PON: begin
        nxt.pon = 1'b0;
        nxt.bor = BOR_PON_VAL;
        nxt.tmo = 1'b1;
        nxt.pdn = 1'b1;
      end
      EV_BROWN: begin
        nxt.bor = 1'b0;
        nxt.tmo = 1'b1;
        nxt.pdn = 1'b1;
      end
      EV_WDT_SLEEP: begin
        nxt.tmo = 1'b0;
        nxt.pdn = 1'b0;
      end
      EV_WDT_RUN: begin
        nxt.tmo = 1'b0;
      end
      EV_EXT_SLEEP, EV_SLEEP: begin
        nxt.tmo = 1'b1;
        nxt.pdn = 1'b0;
      end
      EV_EXT_RUN: begin
        nxt = cur;
      end
      EV_NONE: begin
        if (sw_wr) begin
          nxt.pon = sw_pon;
          nxt.bor = sw_bor;
        end
      end
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/rst_cause_bus.sv
module rst_cause_bus
  import rst_cause_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] ADDR_FLAGS = '0,
  parameter logic [ADDR_W-1:0] ADDR_PCTL  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  rc_flags_t         flags,
  output logic              sw_wr,
  output logic              sw_pon,
  output logic              sw_bor,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rd_next;

  assign sw_wr  = wr_en && (addr == ADDR_PCTL);
  assign sw_pon = wdata[PON_BIT];
  assign sw_bor = wdata[BOR_BIT];

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_FLAGS) begin
      rd_next[TMO_BIT] = flags.tmo;
      rd_next[PDN_BIT] = flags.pdn;
    end else if (addr == ADDR_PCTL) begin
      rd_next[PON_BIT] = flags.pon;
      rd_next[BOR_BIT] = flags.bor;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R10: unimplemented bits of the power-control word read zero
  p_pctl_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_PCTL) |=> (rdata[DATA_W-1:2] == '0));

  // R10: unmapped addresses read zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (addr != ADDR_PCTL && addr != ADDR_FLAGS) |=> (rdata == '0));

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 8,
  parameter int                BOD_W       = 2,
  parameter logic [ADDR_W-1:0] ADDR_FLAGS  = '0,
  parameter logic [ADDR_W-1:0] ADDR_PCTL   = 1,
  parameter logic              BOR_PON_VAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_pon,
  input  logic              ev_brown,
  input  logic              ev_wdt_sleep,
  input  logic              ev_wdt_run,
  input  logic              ev_ext_sleep,
  input  logic              ev_ext_run,
  input  logic              ev_sleep,
  input  logic [BOD_W-1:0]  bod_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam rc_flags_t FLAGS_INIT = '{tmo: 1'b1, pdn: 1'b1, pon: 1'b0, bor: BOR_PON_VAL};

  logic [NUM_EV-1:0] strobe;
  logic              bod_en;
  rc_event_e         ev;
  logic              ev_any;
  logic              sw_wr, sw_pon, sw_bor;
  rc_flags_t         flags_q, flags_d;

  // Strobe index equals priority rank (0 highest)
  assign strobe = {ev_sleep, ev_ext_run, ev_ext_sleep, ev_wdt_run,
                   ev_wdt_sleep, ev_brown, ev_pon};
  assign bod_en = |bod_mode;

  rst_cause_arb u_arb (
    .strobe (strobe),
    .bod_en (bod_en),
    .ev     (ev),
    .ev_any (ev_any)
  );

  rst_cause_bus #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ADDR_FLAGS (ADDR_FLAGS),
    .ADDR_PCTL  (ADDR_PCTL)
  ) u_bus (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .wr_en  (wr_en),
    .wdata  (wdata),
    .flags  (flags_q),
    .sw_wr  (sw_wr),
    .sw_pon (sw_pon),
    .sw_bor (sw_bor),
    .rdata  (rdata)
  );

  rst_cause_next #(
    .BOR_PON_VAL (BOR_PON_VAL)
  ) u_next (
    .cur    (flags_q),
    .ev     (ev),
    .sw_wr  (sw_wr && !ev_any),
    .sw_pon (sw_pon),
    .sw_bor (sw_bor),
    .nxt    (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) flags_q <= FLAGS_INIT;
    else     flags_q <= flags_d;
  end

  // R2: power-on strobe loads power-up values
  p_pon_load_r2: assert property (@(posedge clk) disable iff (rst)
    ev_pon |=> (flags_q.pon == 1'b0 && flags_q.bor == BOR_PON_VAL &&
                flags_q.tmo && flags_q.pdn));

  // R3: enabled brown-out clears its flag, keeps power-on flag
  p_brown_r3: assert property (@(posedge clk) disable iff (rst)
    (ev_brown && bod_en && !ev_pon) |=>
      (!flags_q.bor && flags_q.tmo && flags_q.pdn && $stable(flags_q.pon)));

  // R4: disabled brown-out alone changes nothing
  p_brown_off_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe == 7'b0000010 && !bod_en && !wr_en) |=> $stable(flags_q));

  // R5: running watchdog alone clears only the timeout flag
  p_wdt_run_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe == 7'b0001000 && !wr_en) |=>
      (!flags_q.tmo && $stable(flags_q.pdn) && $stable(flags_q.pon) &&
       $stable(flags_q.bor)));

  // R8: sleep entry alone
  p_sleep_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe == 7'b1000000) |=> (flags_q.tmo && !flags_q.pdn));

  // R11: write colliding with an idle-rule reset is dropped
  p_wr_blocked_r11: assert property (@(posedge clk) disable iff (rst)
    (strobe == 7'b0100000 && wr_en) |=> $stable(flags_q));

endmodule

// File: tb/test_rst_cause_reg.sv
`timescale 1ns/1ps
module test_rst_cause_reg;

  localparam logic [6:0] S_PON = 7'h01, S_BRN = 7'h02, S_WSL = 7'h04,
                         S_WRN = 7'h08, S_XSL = 7'h10, S_XRN = 7'h20,
                         S_SLP = 7'h40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] stb = '0;
  logic [1:0] bod_mode = 2'b01;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  rst_cause_reg i_rst_cause_reg (
    .clk (clk), .rst (rst),
    .ev_pon (stb[0]), .ev_brown (stb[1]), .ev_wdt_sleep (stb[2]),
    .ev_wdt_run (stb[3]), .ev_ext_sleep (stb[4]), .ev_ext_run (stb[5]),
    .ev_sleep (stb[6]), .bod_mode (bod_mode),
    .addr (addr), .wr_en (wr_en), .wdata (wdata), .rdata (rdata)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a;
    @(posedge clk);
    @(negedge clk); v = rdata;
  endtask

  // Write and strobes presented in the same cycle
  task automatic drive(input logic [6:0] s, input logic w, input logic [3:0] a,
                       input logic [7:0] d);
    @(negedge clk); stb = s; wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); stb = '0; wr_en = 1'b0;
  endtask

  task automatic expect_state(input string tag, input logic [1:0] fl, input logic [7:0] pc);
    logic [7:0] v;
    rd(4'd0, v); chk({tag, " flags"}, v, {6'b0, fl});
    rd(4'd1, v); chk({tag, " pctl"}, v, pc);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    expect_state("R1 reset", 2'b11, 8'h01);
  endtask

  task automatic t_sw;
    logic [7:0] v;
    drive('0, 1'b1, 4'd1, 8'hFF);
    expect_state("R9 write pctl / R10 upper zero", 2'b11, 8'h03);
    drive('0, 1'b1, 4'd0, 8'h00);
    expect_state("R9 flags read-only", 2'b11, 8'h03);
    rd(4'd5, v); chk("R10 unmapped", v, 8'h00);
  endtask

  task automatic t_events;
    drive(S_WRN, 1'b0, 4'd0, 8'h00);
    expect_state("R5 wdt run", 2'b01, 8'h03);
    drive(S_SLP, 1'b0, 4'd0, 8'h00);
    expect_state("R8 sleep", 2'b10, 8'h03);
    drive(S_WSL, 1'b0, 4'd0, 8'h00);
    expect_state("R6 wdt sleep", 2'b00, 8'h03);
    drive(S_XRN, 1'b0, 4'd0, 8'h00);
    expect_state("R7 ext run", 2'b00, 8'h03);
    drive(S_XSL, 1'b0, 4'd0, 8'h00);
    expect_state("R7 ext sleep", 2'b10, 8'h03);
  endtask

  task automatic t_brown;
    bod_mode = 2'b01;
    drive(S_BRN, 1'b0, 4'd0, 8'h00);
    expect_state("R3 brown enabled", 2'b11, 8'h02);
    drive('0, 1'b1, 4'd1, 8'h03);
    drive(S_WRN, 1'b0, 4'd0, 8'h00);
    bod_mode = 2'b00;
    drive(S_BRN, 1'b0, 4'd0, 8'h00);
    expect_state("R4 brown disabled", 2'b01, 8'h03);
    drive(S_BRN, 1'b1, 4'd1, 8'h00);
    expect_state("R4 R11 disabled brown lets write", 2'b01, 8'h00);
    bod_mode = 2'b01;
  endtask

  task automatic t_collide;
    drive('0, 1'b1, 4'd1, 8'h03);
    drive(S_XRN, 1'b1, 4'd1, 8'h00);
    expect_state("R11 write vs ext run", 2'b01, 8'h03);
    drive(S_SLP, 1'b1, 4'd1, 8'h00);
    expect_state("R11 write vs sleep", 2'b10, 8'h03);
  endtask

  task automatic t_priority;
    drive(S_PON | S_WRN, 1'b0, 4'd0, 8'h00);
    expect_state("R12 R2 pon beats wdt", 2'b11, 8'h01);
    drive('0, 1'b1, 4'd1, 8'h03);
    drive(S_WRN | S_SLP, 1'b0, 4'd0, 8'h00);
    expect_state("R12 wdt run beats sleep", 2'b01, 8'h03);
    drive(S_XRN | S_SLP, 1'b0, 4'd0, 8'h00);
    expect_state("R12 ext run beats sleep", 2'b01, 8'h03);
    drive(S_BRN | S_WSL, 1'b0, 4'd0, 8'h00);
    expect_state("R12 brown beats wdt sleep", 2'b11, 8'h02);
  endtask

  task automatic t_pon;
    drive('0, 1'b1, 4'd1, 8'h03);
    drive(S_WSL, 1'b0, 4'd0, 8'h00);
    drive(S_PON, 1'b0, 4'd0, 8'h00);
    expect_state("R2 power-on", 2'b11, 8'h01);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    t_sw;
    t_events;
    t_brown;
    t_collide;
    t_priority;
    t_pon;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end

endmodule